// File: doc/BRIEF.md
# Single-bit Boolean processor

This block is the bit-manipulation unit of a small controller datapath. It holds the carry flag and uses it as a one-bit accumulator. Each operation works on the carry and on one addressed bit. The surrounding datapath does three things for it: it decodes the bit address, it reads the addressed bit, and it presents the bit together with a 5-bit operation code and a valid strobe.

In the same cycle the block returns four results:
- the write-back value for the addressed bit;
- a write enable for that bit;
- the address to write;
- a branch-taken indication for the bit-test and carry-test jumps.

The new carry value is registered on the clock edge that ends the operation.

The bit-level operations are clear, set and complement, each on the carry or on the bit. Carry can be ANDed or ORed with the bit or with its inverse. A move copies carry into the bit, or the bit into carry. The conditional tests cover carry set or clear, bit set or clear, and a test-and-clear form. That last form jumps and clears the bit in one operation.

Three addresses are parameters: the parity, overflow and auxiliary-carry flag bits. Write-back to any of them is always blocked.

Top module: `bool_bit_unit`

## Requirements
- R1: After reset `carry` is 0. While `op_valid` is 0, `bit_wr_en` and `branch_taken` are 0 and `carry` keeps its value across the clock edge.
- R2: Codes 1, 2 and 3 clear, set and complement the carry on the next edge. `bit_wr_en` stays 0 for all three.
- R3: Codes 4, 5 and 6 write the addressed bit with 0, 1 and the inverse of `bit_rd`. For these codes `bit_wr_en` is 1, `bit_wr_addr` equals `bit_addr`, and carry is unchanged.
- R4: Four codes combine carry with the bit and load the result into carry, with `bit_wr_en` at 0:
  - code 7 loads carry AND bit;
  - code 8 loads carry AND NOT bit;
  - code 9 loads carry OR bit;
  - code 10 loads carry OR NOT bit.
- R5: Code 11 loads `bit_rd` into carry and does not write the bit. Code 12 writes the current carry into the bit and leaves carry unchanged.
- R6: Code 13 raises `branch_taken` when carry is 1. Code 14 raises it when carry is 0. Neither code writes the bit or changes carry.
- R7: Code 15 raises `branch_taken` when `bit_rd` is 1. Code 16 raises it when `bit_rd` is 0. Neither code writes the bit or changes carry.
- R8: Code 17 (test and clear) behaves differently depending on the bit:
  - when `bit_rd` is 1, it raises `branch_taken` and writes 0 with `bit_wr_en` at 1;
  - when `bit_rd` is 0, both `branch_taken` and `bit_wr_en` are 0.
- R9: When `bit_addr` equals PAR_ADDR, OV_ADDR or AC_ADDR, `bit_wr_en` is 0 for every code. The carry result and `branch_taken` are not affected.
- R10: Code 0 and codes 18 to 31 do nothing: no write, no branch, and carry is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | OP_W | Operation code |
| bit_addr | input | ADDR_W | Address of the operated bit |
| bit_rd | input | 1 | Current value of the addressed bit |
| carry | output | 1 | Carry flag (registered) |
| bit_wr_en | output | 1 | Write the addressed bit this cycle |
| bit_wr_addr | output | ADDR_W | Address to write |
| bit_wr_data | output | 1 | Value to write |
| branch_taken | output | 1 | Conditional jump taken |

## Verification
The bench builds the block with its default parameters. These are an 8-bit address, a 5-bit code, and the protected flag addresses 0xD0, 0xD2 and 0xD6.

About a quarter of the random addresses are drawn from the three protected values. This reaches the write-blocking rule under every code, including test-and-clear on a set bit. Random codes cover the whole 5-bit space, so the unused codes 18 to 31 are reached as well. Because the carry is modelled across long random chains, the combining codes are checked against every carry history.

// File: rtl/bool_bit_unit.sv
module bool_bit_unit #(
  parameter int ADDR_W = 8,
  parameter int OP_W = 5,
  parameter logic [ADDR_W-1:0] PAR_ADDR = 8'hD0,
  parameter logic [ADDR_W-1:0] OV_ADDR  = 8'hD2,
  parameter logic [ADDR_W-1:0] AC_ADDR  = 8'hD6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_rd,
  output logic              carry,
  output logic              bit_wr_en,
  output logic [ADDR_W-1:0] bit_wr_addr,
  output logic              bit_wr_data,
  output logic              branch_taken
);

  localparam logic [OP_W-1:0] C_CLR  = OP_W'(1);
  localparam logic [OP_W-1:0] C_SET  = OP_W'(2);
  localparam logic [OP_W-1:0] C_CPL  = OP_W'(3);
  localparam logic [OP_W-1:0] B_CLR  = OP_W'(4);
  localparam logic [OP_W-1:0] B_SET  = OP_W'(5);
  localparam logic [OP_W-1:0] B_CPL  = OP_W'(6);
  localparam logic [OP_W-1:0] C_AND  = OP_W'(7);
  localparam logic [OP_W-1:0] C_ANDN = OP_W'(8);
  localparam logic [OP_W-1:0] C_OR   = OP_W'(9);
  localparam logic [OP_W-1:0] C_ORN  = OP_W'(10);
  localparam logic [OP_W-1:0] C_LD   = OP_W'(11);
  localparam logic [OP_W-1:0] B_ST   = OP_W'(12);
  localparam logic [OP_W-1:0] J_C    = OP_W'(13);
  localparam logic [OP_W-1:0] J_NC   = OP_W'(14);
  localparam logic [OP_W-1:0] J_B    = OP_W'(15);
  localparam logic [OP_W-1:0] J_NB   = OP_W'(16);
  localparam logic [OP_W-1:0] J_BC   = OP_W'(17);

  logic carry_nx, wr_req, wr_val, take;
  logic prot;

  assign prot = (bit_addr == PAR_ADDR) || (bit_addr == OV_ADDR) || (bit_addr == AC_ADDR);

  always_comb begin
    carry_nx = carry;
    wr_req   = 1'b0;
    wr_val   = 1'b0;
    take     = 1'b0;
    case (op_code)
      C_CLR:  carry_nx = 1'b0;
      C_SET:  carry_nx = 1'b1;
      C_CPL:  carry_nx = ~carry;
      B_CLR:  begin wr_req = 1'b1; wr_val = 1'b0; end
      B_SET:  begin wr_req = 1'b1; wr_val = 1'b1; end
      B_CPL:  begin wr_req = 1'b1; wr_val = ~bit_rd; end
      C_AND:  carry_nx = carry & bit_rd;
      C_ANDN: carry_nx = carry & ~bit_rd;
      C_OR:   carry_nx = carry | bit_rd;
      C_ORN:  carry_nx = carry | ~bit_rd;
      C_LD:   carry_nx = bit_rd;
      B_ST:   begin wr_req = 1'b1; wr_val = carry; end
      J_C:    take = carry;
      J_NC:   take = ~carry;
      J_B:    take = bit_rd;
      J_NB:   take = ~bit_rd;
      J_BC:   begin take = bit_rd; wr_req = bit_rd; wr_val = 1'b0; end
      default: ;
    endcase
  end

  assign bit_wr_en    = op_valid & wr_req & ~prot;
  assign bit_wr_addr  = bit_addr;
  assign bit_wr_data  = wr_val;
  assign branch_taken = op_valid & take;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        carry <= 1'b0;
    else if (op_valid) carry <= carry_nx;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!bit_wr_en && !branch_taken));

  a_r1_idle_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(carry));

  a_r9_protected_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_addr == PAR_ADDR || bit_addr == OV_ADDR || bit_addr == AC_ADDR) |-> !bit_wr_en);

  a_r8_jbc_clear_bit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == J_BC && !bit_rd) |-> (!bit_wr_en && !branch_taken));

  a_r6_jump_carry_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == J_C || op_code == J_NC)) |=> $stable(carry));

  a_r4_combine_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= C_AND && op_code <= C_LD) |-> !bit_wr_en);

  a_r10_unused_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == '0 || op_code > J_BC)) |-> (!bit_wr_en && !branch_taken));

endmodule

// File: tb/bool_bit_unit_test.sv
`timescale 1ns/1ps
module bool_bit_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] bit_addr = '0;
  logic bit_rd = 1'b0;
  logic carry, bit_wr_en, bit_wr_data, branch_taken;
  logic [7:0] bit_wr_addr;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic m_c = 1'b0;

  always #5 clk = ~clk;

  bool_bit_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bit_addr(bit_addr), .bit_rd(bit_rd), .carry(carry),
    .bit_wr_en(bit_wr_en), .bit_wr_addr(bit_wr_addr),
    .bit_wr_data(bit_wr_data), .branch_taken(branch_taken)
  );

  function automatic logic is_prot(input logic [7:0] a);
    return a == 8'hD0 || a == 8'hD2 || a == 8'hD6;
  endfunction

  // returns {next carry, write enable, write data, taken}
  function automatic logic [3:0] model(input logic v, input logic [4:0] op,
                                       input logic [7:0] a, input logic b, input logic c);
    logic nc, we, wd, tk;
    nc = c; we = 0; wd = 0; tk = 0;
    if (v) begin
      if (op == 1) nc = 0;
      else if (op == 2) nc = 1;
      else if (op == 3) nc = !c;
      else if (op == 4) begin we = 1; wd = 0; end
      else if (op == 5) begin we = 1; wd = 1; end
      else if (op == 6) begin we = 1; wd = !b; end
      else if (op == 7) nc = c && b;
      else if (op == 8) nc = c && !b;
      else if (op == 9) nc = c || b;
      else if (op == 10) nc = c || !b;
      else if (op == 11) nc = b;
      else if (op == 12) begin we = 1; wd = c; end
      else if (op == 13) tk = c;
      else if (op == 14) tk = !c;
      else if (op == 15) tk = b;
      else if (op == 16) tk = !b;
      else if (op == 17) begin tk = b; we = b; wd = 0; end
      if (is_prot(a)) we = 0;
    end
    return {nc, we, wd, tk};
  endfunction

  function automatic string req_of(input logic [4:0] op, input logic [7:0] a);
    if (is_prot(a)) return "R9";
    if (op >= 1 && op <= 3) return "R2";
    if (op >= 4 && op <= 6) return "R3";
    if (op >= 7 && op <= 10) return "R4";
    if (op == 11 || op == 12) return "R5";
    if (op == 13 || op == 14) return "R6";
    if (op == 15 || op == 16) return "R7";
    if (op == 17) return "R8";
    return "R10";
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [4:0] op, input logic [7:0] a, input logic b);
    logic [3:0] e;
    string r;
    @(negedge clk);
    op_valid = v; op_code = op; bit_addr = a; bit_rd = b;
    e = model(v, op, a, b, m_c);
    r = v ? req_of(op, a) : "R1";
    #1;
    check(r, "bit_wr_en", {7'b0, bit_wr_en}, {7'b0, e[2]});
    if (e[2]) begin
      check(r, "bit_wr_data", {7'b0, bit_wr_data}, {7'b0, e[1]});
      check(r, "bit_wr_addr", bit_wr_addr, a);
    end
    check(r, "branch_taken", {7'b0, branch_taken}, {7'b0, e[0]});
    @(posedge clk); #1;
    m_c = e[3];
    check(r, "carry", {7'b0, carry}, {7'b0, m_c});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset carry", {7'b0, carry}, 8'h00);
    check("R1", "reset wr_en", {7'b0, bit_wr_en}, 8'h00);
    rst_n = 1'b1;
    // directed corners
    step(1, 5'd2, 8'h20, 0);        // R2 set carry
    step(0, 5'd1, 8'h20, 0);        // R1 idle, carry holds
    step(1, 5'd3, 8'h20, 1);        // R2 complement -> 0
    step(1, 5'd5, 8'h21, 0);        // R3 set bit
    step(1, 5'd6, 8'h22, 1);        // R3 complement bit
    step(1, 5'd2, 8'h22, 0);
    step(1, 5'd8, 8'h23, 1);        // R4 and-not -> 0
    step(1, 5'd10, 8'h23, 0);       // R4 or-not -> 1
    step(1, 5'd12, 8'h24, 0);       // R5 store carry
    step(1, 5'd11, 8'h24, 0);       // R5 load bit -> 0
    step(1, 5'd14, 8'h25, 0);       // R6 jnc taken
    step(1, 5'd13, 8'h25, 1);       // R6 jc not taken
    step(1, 5'd15, 8'h26, 1);       // R7
    step(1, 5'd16, 8'h26, 1);       // R7
    step(1, 5'd17, 8'h27, 1);       // R8 taken and clear
    step(1, 5'd17, 8'h27, 0);       // R8 no write
    step(1, 5'd17, 8'hD0, 1);       // R9 taken, write blocked
    step(1, 5'd4, 8'hD2, 1);        // R9
    step(1, 5'd12, 8'hD6, 1);       // R9
    step(1, 5'd0, 8'h30, 1);        // R10
    step(1, 5'd25, 8'h30, 1);       // R10
    void'($urandom(32'd1234));
    for (int i = 0; i < 1500; i++) begin
      case ($urandom % 4)
        0: begin
          case ($urandom % 3)
            0: a = 8'hD0;
            1: a = 8'hD2;
            default: a = 8'hD6;
          endcase
        end
        default: a = 8'($urandom);
      endcase
      step(($urandom % 8) != 0, 5'($urandom), a, 1'($urandom));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule